// File: doc/BRIEF.md
# Packed quad-byte add/subtract unit

This block is an execution unit of a SIMD media extension. It owns a file of sixteen 32-bit extension registers in which index 0 is a hard-wired zero. Each valid instruction names two source registers and a destination. Both sources are split into four independent byte lanes. The lower two lanes and the upper two lanes each add or subtract under their own pattern bit, and the packed 32-bit result is written back on the clock edge that samples the instruction.

A minor opcode, decoded upstream, picks this operation. Any other minor opcode is flagged as reserved and leaves the registers alone. A non-zero padding field or a zero destination turns the instruction into a no-op. A second write port lets neighbouring extension units, such as loads and moves, place values in the shared register file. A combinational debug port reads any register.

Top module: `qb_quad_addsub`

## Requirements
- R1: A synchronous active-high reset clears all fifteen physical registers and drops `done` and `rsvd`.
- R2: Byte lanes 0 and 1 (bits 15:0) compute first source minus second source when pattern bit 24 of the instruction is 1, and first plus second when it is 0.
- R3: Byte lanes 2 and 3 (bits 31:16) compute first source minus second source when instruction bit 25 is 1, and the sum when it is 0.
- R4: Each lane wraps modulo 256: no saturation, and no carry or borrow passes into a neighbouring lane.
- R5: A valid instruction whose `minor_op` is not 0x07 raises `rsvd` for one cycle and changes no register.
- R6: A non-zero padding field (bits 23:21) makes a valid instruction change no register and raise no `rsvd`.
- R7: Destination index 0 (bits 9:6) writes nothing. Debug index 0 always reads zero.
- R8: Source index 0 (first source at bits 13:10, second at bits 17:14) reads as zero, so two zero sources write zero to the destination.
- R9: `done` pulses for one cycle after every valid instruction. A result can be read on the next cycle, including as a source of the instruction that follows at once.
- R10: `dbg_data` shows the register selected by `dbg_idx` in the same cycle, with no register stage.
- R11: `ext_we` writes `ext_wdata` into register `ext_idx` (non-zero) at the clock edge. If an executing instruction targets the same register in the same cycle, the instruction result is kept.
- R12: Instruction bits outside the named fields have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_word | input | 32 | Instruction word |
| minor_op | input | 6 | Pre-decoded minor opcode |
| ext_we | input | 1 | Write strobe from another extension unit |
| ext_idx | input | 4 | Register index for that write |
| ext_wdata | input | 32 | Data for that write |
| dbg_idx | input | 4 | Debug read index |
| dbg_data | output | 32 | Debug read data |
| done | output | 1 | One-cycle completion pulse |
| rsvd | output | 1 | One-cycle reserved-instruction flag |

## Verification
The hardest cases to reach are those where two writes meet: an outside write and an instruction result landing on the same register in the same cycle, and an instruction that reads the destination of the instruction just before it. Registers come out of reset holding zero, and add/subtract alone can never make a non-zero value from zero. The stimulus therefore first seeds registers through the outside write port with lane values chosen to wrap (0xFF, 0x80, 0x7F). It then issues the collision and the back-to-back dependency in consecutive cycles, and scans all sixteen registers through the debug port on every clock.

// File: rtl/qb_pkg.sv
package qb_pkg;

    localparam int XLEN     = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = XLEN / LANE_W;
    localparam int NREGS    = 16;
    localparam int IDX_W    = $clog2(NREGS);
    localparam int MINOR_W  = 6;
    localparam logic [MINOR_W-1:0] MINOR_QADD = 6'h07;

    typedef struct packed {
        logic [1:0]       pattern;
        logic [2:0]       pad;
        logic [IDX_W-1:0] src2;
        logic [IDX_W-1:0] src1;
        logic [IDX_W-1:0] dst;
    } qb_fields_t;

    typedef enum logic [1:0] {
        QB_IDLE = 2'd0,
        QB_EXEC = 2'd1,
        QB_NOP  = 2'd2,
        QB_RSVD = 2'd3
    } qb_kind_t;

    typedef struct packed {
        qb_kind_t   kind;
        qb_fields_t f;
    } qb_op_t;

    function automatic qb_fields_t qb_extract(input logic [XLEN-1:0] w);
        qb_fields_t r;
        r.pattern = w[25:24];
        r.pad     = w[23:21];
        r.src2    = w[17:14];
        r.src1    = w[13:10];
        r.dst     = w[9:6];
        return r;
    endfunction

    function automatic logic [LANE_W-1:0] qb_lane(input logic [LANE_W-1:0] a,
                                                  input logic [LANE_W-1:0] b,
                                                  input logic              sub);
        return sub ? (a - b) : (a + b);
    endfunction

endpackage

// File: rtl/qb_decode.sv
module qb_decode
    import qb_pkg::*;
(
    input  logic               valid,
    input  logic [XLEN-1:0]    word,
    input  logic [MINOR_W-1:0] minor,
    output qb_op_t             op
);
    qb_fields_t f;

    always_comb begin
        f       = qb_extract(word);
        op.f    = f;
        if (!valid)
            op.kind = QB_IDLE;
        else if (minor != MINOR_QADD)
            op.kind = QB_RSVD;
        else if (f.pad != 3'd0 || f.dst == '0)
            op.kind = QB_NOP;
        else
            op.kind = QB_EXEC;
    end
endmodule

// File: rtl/qb_lanes.sv
module qb_lanes
    import qb_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int LW = LANE_W,
    localparam int NL = W / LW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   pattern,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int PBIT = (i < NL / 2) ? 0 : 1;
        assign y[i*LW +: LW] = qb_lane(a[i*LW +: LW], b[i*LW +: LW], pattern[PBIT]);
    end
endmodule

// File: rtl/qb_regfile.sv
module qb_regfile
    import qb_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREGS,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_a,
    input  logic [IW-1:0] wa_a,
    input  logic [W-1:0]  wd_a,
    input  logic          we_b,
    input  logic [IW-1:0] wa_b,
    input  logic [W-1:0]  wd_b,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    input  logic [IW-1:0] rad,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rdd
);
    logic [W-1:0] mem [N];

    assign mem[0] = '0;

    for (genvar r = 1; r < N; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[r] <= '0;
            else if (we_a && wa_a == IW'(r))
                mem[r] <= wd_a;
            else if (we_b && wa_b == IW'(r))
                mem[r] <= wd_b;
        end
    end

    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];
    assign rdd = mem[rad];

    // R9 / R11: an instruction result is present the next cycle, even against a colliding outside write
    a_r9_result_visible: assert property (@(posedge clk) disable iff (rst)
        (we_a && wa_a != '0) |=> (mem[$past(wa_a)] == $past(wd_a)));

    a_r11_outside_write: assert property (@(posedge clk) disable iff (rst)
        (we_b && wa_b != '0 && !(we_a && wa_a == wa_b)) |=> (mem[$past(wa_b)] == $past(wd_b)));
endmodule

// File: rtl/qb_quad_addsub.sv
module qb_quad_addsub
    import qb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [XLEN-1:0]    instr_word,
    input  logic [MINOR_W-1:0] minor_op,
    input  logic               ext_we,
    input  logic [IDX_W-1:0]   ext_idx,
    input  logic [XLEN-1:0]    ext_wdata,
    input  logic [IDX_W-1:0]   dbg_idx,
    output logic [XLEN-1:0]    dbg_data,
    output logic               done,
    output logic               rsvd
);
    qb_op_t          op;
    logic [XLEN-1:0] src1_val, src2_val, result;
    logic            wr_en;

    qb_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .minor (minor_op),
        .op    (op)
    );

    qb_lanes #(.W(XLEN), .LW(LANE_W)) u_lanes (
        .a       (src1_val),
        .b       (src2_val),
        .pattern (op.f.pattern),
        .y       (result)
    );

    assign wr_en = (op.kind == QB_EXEC);

    qb_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we_a (wr_en),
        .wa_a (op.f.dst),
        .wd_a (result),
        .we_b (ext_we),
        .wa_b (ext_idx),
        .wd_b (ext_wdata),
        .ra1  (op.f.src1),
        .ra2  (op.f.src2),
        .rad  (dbg_idx),
        .rd1  (src1_val),
        .rd2  (src2_val),
        .rdd  (dbg_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            rsvd <= 1'b0;
        end else begin
            done <= instr_valid;
            rsvd <= (op.kind == QB_RSVD);
        end
    end

    a_r5_reserved_no_write: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && minor_op != MINOR_QADD) |-> !wr_en);

    a_r6_pad_no_write: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_word[23:21] != 3'd0) |=> !rsvd || $past(minor_op) != MINOR_QADD);

    a_r7_dbg_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == '0) |-> (dbg_data == '0));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !done && !rsvd);
endmodule

// File: tb/test_qb_quad_addsub.sv
`timescale 1ns/10ps
module test_qb_quad_addsub;
    localparam real CLK_PERIOD = 10.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [5:0]  minor_op = '0;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_idx = '0;
    logic [31:0] ext_wdata = '0;
    logic [3:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic        done, rsvd;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    logic [31:0] model [16];
    logic        exp_done = 1'b0;
    logic        exp_rsvd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qb_quad_addsub i_qb_quad_addsub (
        .clk, .rst, .instr_valid, .instr_word, .minor_op,
        .ext_we, .ext_idx, .ext_wdata, .dbg_idx, .dbg_data, .done, .rsvd
    );

    initial for (int k = 0; k < 16; k++) model[k] = '0;

    function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] pat);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            int x = (a >> (8*i)) & 255;
            int y = (b >> (8*i)) & 255;
            int sub = (i < 2) ? pat[0] : pat[1];
            int v = sub ? (x - y + 256) % 256 : (x + y) % 256;
            r = r | (32'(v) << (8*i));
        end
        return r;
    endfunction

    function automatic logic [31:0] enc(input int pat, input int pad, input int s2,
                                       input int s1, input int d);
        return (32'(pat) << 24) | (32'(pad) << 21) | (32'(s2) << 14) | (32'(s1) << 10) | (32'(d) << 6);
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) model[k] <= '0;
            exp_done <= 1'b0;
            exp_rsvd <= 1'b0;
        end else begin
            logic [31:0] a, b;
            int d;
            a = model[instr_word[13:10]];
            b = model[instr_word[17:14]];
            d = int'(instr_word[9:6]);
            exp_done <= instr_valid;
            exp_rsvd <= instr_valid && minor_op != 6'h07;
            if (ext_we && ext_idx != 0) model[ext_idx] <= ext_wdata;
            if (instr_valid && minor_op == 6'h07 && instr_word[23:21] == 0 && d != 0)
                model[d] <= ref_op(a, b, instr_word[25:24]);
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", cur_req, what, act, exp);
        end
    endtask

    // Compare everything observable, then drive the next cycle's inputs
    task automatic step(input string req, input logic v, input logic [5:0] mo, input logic [31:0] w,
                        input logic ew, input logic [3:0] ei, input logic [31:0] ed);
        @(negedge clk);
        check("done", 32'(done), 32'(exp_done));
        check("rsvd", 32'(rsvd), 32'(exp_rsvd));
        for (int k = 0; k < 16; k++) begin
            dbg_idx = 4'(k);
            #0.1;
            check($sformatf("dbg[%0d]", k), dbg_data, model[k]);  // R10 / R7 for index 0
        end
        cur_req     = req;
        instr_valid = v;
        minor_op    = mo;
        instr_word  = w;
        ext_we      = ew;
        ext_idx     = ei;
        ext_wdata   = ed;
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 6'h07, 32'h0, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic load(input int idx, input logic [31:0] val);
        step("R11", 1'b0, 6'h00, 32'h0, 1'b1, 4'(idx), val);
    endtask

    task automatic qadd(input string req, input int pat, input int s2, input int s1, input int d);
        step(req, 1'b1, 6'h07, enc(pat, 0, s2, s1, d), 1'b0, 4'h0, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        idle("R1"); idle("R1");
        @(negedge clk) rst = 1'b0;
        idle("R1");
        // seed registers through the outside write port
        load(1, 32'h10FF_7F80);
        load(2, 32'h0101_8081);
        load(3, 32'hFFFF_FFFF);
        load(15, 32'h1234_5678);
        load(0, 32'hDEAD_BEEF);          // R7: index 0 stays zero
        // R2 / R3 / R4: all four patterns, wrapping lanes
        qadd("R4", 0, 2, 1, 4);
        qadd("R2", 1, 2, 1, 5);
        qadd("R3", 2, 2, 1, 6);
        qadd("R3", 3, 2, 1, 7);
        qadd("R4", 0, 3, 3, 12);
        idle("R4");
        // R12: stray bits outside the fields
        step("R12", 1'b1, 6'h07, enc(1, 0, 15, 3, 13) | 32'hFC00_003F | 32'h0010_0000, 1'b0, 4'h0, 32'h0);
        // R5: reserved minor opcodes
        step("R5", 1'b1, 6'h05, enc(0, 0, 2, 1, 8), 1'b0, 4'h0, 32'h0);
        step("R5", 1'b1, 6'h3F, enc(3, 0, 2, 1, 8), 1'b0, 4'h0, 32'h0);
        idle("R5");
        // R6: non-zero padding values
        qadd("R6", 0, 2, 1, 8) ;
        step("R6", 1'b1, 6'h07, enc(0, 1, 2, 1, 8), 1'b0, 4'h0, 32'h0);
        step("R6", 1'b1, 6'h07, enc(1, 4, 3, 1, 8), 1'b0, 4'h0, 32'h0);
        // R7: destination zero
        qadd("R7", 0, 2, 1, 0);
        // R8: zero sources
        qadd("R8", 0, 0, 0, 1);
        qadd("R8", 1, 3, 0, 14);
        qadd("R8", 3, 0, 15, 11);
        // R9: back-to-back dependency chain
        qadd("R9", 0, 15, 2, 9);
        qadd("R9", 0, 9, 9, 10);
        qadd("R9", 3, 10, 9, 9);
        // R11: collision on the same register in one cycle, instruction wins
        step("R11", 1'b1, 6'h07, enc(0, 0, 15, 15, 11), 1'b1, 4'd11, 32'hAAAA_5555);
        // R11: outside write alongside a no-op instruction to the same register
        step("R11", 1'b1, 6'h07, enc(0, 2, 15, 15, 11), 1'b1, 4'd11, 32'h0BAD_F00D);
        idle("R9"); idle("R9");
        // R1: reset again mid-run
        @(negedge clk) rst = 1'b1;
        idle("R1");
        @(negedge clk) rst = 1'b0;
        idle("R1"); idle("R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule